// File: doc/BRIEF.md
# Receive FIFO DMA Request Scheduler

Many serial packet engines write dwords into a shared receive FIFO, and each engine owns one channel's share of it. This block keeps a dword count and a pending end-of-frame count for every channel. It decides when a channel holds enough data to be worth a DMA burst to the host bus. A channel becomes ready when its count climbs past a programmable high watermark. It also becomes ready when a frame ends before that level is reached, so short packets are never left waiting for more data.

When one or more channels are ready, a scheduler registers one of them and offers it to the DMA engine. The host picks the selection rule, either lowest-index-first or a rotating round-robin, and can change it while the block runs. Once granted, the DMA reads dwords from the selected channel until the count reaches zero, crossing packet boundaries if needed, and then pulses burst-done. The selection stays frozen from the offer until that pulse.

Top module: `rx_dma_sched`

## Requirements
- R1: A channel is ready (its `chan_ready` bit set) once its dword count is strictly greater than `cfg_high_wm`; a count equal to the watermark with no end-of-frame pending is not ready.
- R2: A `wr_eof` bit sampled while that channel's resulting count is non-zero records a pending frame end, and the channel is ready while any frame end is pending and its count is non-zero, whatever the watermark.
- R3: A `wr_eof` bit on a channel whose count stays zero (no write that cycle) is dropped: the channel does not become ready, and a later write without an end-of-frame does not make it ready.
- R4: With `cfg_rr_mode` = 0 the scheduler selects the ready channel with the lowest index (channel 0 first).
- R5: With `cfg_rr_mode` = 1 the scheduler searches upward from the channel after the one last served (the channel of the most recent burst-done), wrapping from 7 to 0.
- R6: `cfg_rr_mode` may change at any time; the new rule applies to the next selection made while the scheduler is idle.
- R7: `dma_req` rises on the clock edge after a channel's `chan_ready` bit rises while the scheduler is idle; `dma_ch` then holds its value through the offer and the burst until `burst_done`, even if other channels become ready.
- R8: While `burst_busy` is high, each cycle with `rd_en` high removes one dword from the selected channel only; `sel_occ` shows the selected channel's count, and a burst may drain several frames in one go.
- R9: A channel whose count reaches zero drops its ready bit and forgets its pending frame ends; it needs a new watermark crossing or a new end-of-frame to request again.
- R10: A write and a read to the selected channel in the same cycle leave its count unchanged, and a read while the count is zero is ignored (the count stays zero).
- R11: After reset all counts are zero, no channel is ready, `dma_req` and `burst_busy` are low, and round-robin starts its search at channel 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 8 | Per-channel strobe: one dword added to that channel this cycle |
| wr_eof | input | 8 | Per-channel frame-end flag, with or without a dword |
| cfg_high_wm | input | 6 | High watermark in dwords |
| cfg_rr_mode | input | 1 | 1 = round-robin selection, 0 = lowest index first |
| dma_req | output | 1 | A selected channel is offered to the DMA engine |
| dma_ch | output | 3 | Selected channel index |
| dma_grant | input | 1 | DMA engine accepts the offer; burst starts |
| burst_busy | output | 1 | Burst in progress on `dma_ch` |
| rd_en | input | 1 | Burst read strobe: one dword taken from the selected channel |
| burst_done | input | 1 | Pulse ending the burst |
| sel_occ | output | 6 | Dword count of the selected channel |
| chan_ready | output | 8 | Per-channel ready flags |

## Verification
Counts and ready flags are registered once, so `chan_ready` and `sel_occ` change on the same edge that samples a write or read. `dma_req` and a new `dma_ch` come one edge after the ready flag, and `burst_busy` follows `dma_grant` by one edge. The bench drives every input one nanosecond after a rising edge and reads the outputs just after the next edge. It checks the ready flag right after the last write and checks the request only after one more edge. Selection-order tests let the scheduler go back through idle after each burst-done, and they wait for each new offer before they compare its channel.

// File: rtl/rx_sched_pkg.sv
// Package rx_sched_pkg
// Shared types for the receive DMA request scheduler.
// Assumes nothing beyond a 2-bit state encoding.
package rx_sched_pkg;

    typedef enum logic [1:0] {
        SCH_IDLE  = 2'd0,
        SCH_OFFER = 2'd1,
        SCH_BURST = 2'd2
    } sched_state_e;

endpackage

// File: rtl/rx_chan_tracker.sv
// Module rx_chan_tracker
// Keeps one channel's dword count and pending end-of-frame count, and
// raises ready above the watermark or when a frame end is pending.
// Assumes the writer never adds a dword to a full counter without a read.
module rx_chan_tracker #(
    parameter int OCC_W = 6,
    parameter int EOF_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             eof_i,
    input  logic             rd_i,
    input  logic [OCC_W-1:0] hwm_i,
    output logic             ready_o,
    output logic [OCC_W-1:0] occ_o
);

    localparam logic [EOF_W-1:0] EOF_MAX = {EOF_W{1'b1}};

    logic [OCC_W-1:0] occ_q, occ_next;
    logic [EOF_W-1:0] eof_q;
    logic             rd_eff;

    // A read only counts when there is something to take.
    assign rd_eff = rd_i && (occ_q != '0);

    // Next count from one possible write and one possible read.
    always_comb begin
        occ_next = occ_q;
        if (wr_i && !rd_eff)
            occ_next = occ_q + OCC_W'(1);
        else if (!wr_i && rd_eff)
            occ_next = occ_q - OCC_W'(1);
    end

    // Register the count and the pending frame ends; emptying clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
            eof_q <= '0;
        end else begin
            occ_q <= occ_next;
            if (occ_next == '0)
                eof_q <= '0;
            else if (eof_i && eof_q != EOF_MAX)
                eof_q <= eof_q + EOF_W'(1);
        end
    end

    // Ready above the watermark, or with a frame end and data present.
    assign ready_o = (occ_q > hwm_i) || ((eof_q != '0) && (occ_q != '0));
    assign occ_o   = occ_q;

    AST_EMPTY_NO_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == '0) |-> (eof_q == '0)); // R3

    AST_DRAIN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == OCC_W'(1) && rd_i && !wr_i) |=> !ready_o); // R9

endmodule

// File: rtl/rx_sched_arbiter.sv
// Module rx_sched_arbiter
// Combinational pick among ready channels: lowest index first, or an
// upward search starting after the last served channel.
// Assumes last_i holds a valid channel index.
module rx_sched_arbiter #(
    parameter int NUM_CH = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] ready_i,
    input  logic              rr_mode_i,
    input  logic [CH_W-1:0]   last_i,
    output logic [CH_W-1:0]   pick_o,
    output logic              valid_o
);

    // Scan all channels in the order the mode dictates; first ready wins.
    always_comb begin
        int idx;
        pick_o  = '0;
        valid_o = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rr_mode_i)
                idx = (int'(last_i) + 1 + i) % NUM_CH;
            else
                idx = i;
            if (!valid_o && ready_i[idx]) begin
                valid_o = 1'b1;
                pick_o  = CH_W'(idx);
            end
        end
    end

endmodule

// File: rtl/rx_sched_fsm.sv
// Module rx_sched_fsm
// Registers the chosen channel, offers it to the DMA engine, holds it
// through the burst, and records it as last served on burst-done.
// Assumes the DMA engine grants only while an offer is up.
module rx_sched_fsm
    import rx_sched_pkg::*;
#(
    parameter int NUM_CH = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ready_i,
    input  logic              rr_mode_i,
    input  logic [CH_W-1:0]   pick_i,
    input  logic              pick_vld_i,
    input  logic              grant_i,
    input  logic              done_i,
    output logic [CH_W-1:0]   sel_o,
    output logic [CH_W-1:0]   last_o,
    output logic              req_o,
    output logic              busy_o
);

    sched_state_e    st_q;
    logic [CH_W-1:0] sel_q, last_q;

    // Step through idle, offer and burst; latch choices on entry and exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SCH_IDLE;
            sel_q  <= '0;
            last_q <= CH_W'(NUM_CH - 1);
        end else begin
            case (st_q)
                SCH_IDLE: if (pick_vld_i) begin
                    sel_q <= pick_i;
                    st_q  <= SCH_OFFER;
                end
                SCH_OFFER: if (grant_i) st_q <= SCH_BURST;
                SCH_BURST: if (done_i) begin
                    last_q <= sel_q;
                    st_q   <= SCH_IDLE;
                end
                default: st_q <= SCH_IDLE;
            endcase
        end
    end

    assign sel_o  = sel_q;
    assign last_o = last_q;
    assign req_o  = (st_q == SCH_OFFER);
    assign busy_o = (st_q == SCH_BURST);

    // Previous-cycle ready flags, used only by the priority check.
    logic [NUM_CH-1:0] rdy_d;
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_d <= '0;
        else        rdy_d <= ready_i;
    end

    AST_REQ_HAS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> ready_i[sel_q]); // R7

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != SCH_IDLE && !(st_q == SCH_BURST && done_i)) |=> $stable(sel_q)); // R7

    AST_PRIO_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SCH_IDLE && (|ready_i) && !rr_mode_i)
        |=> ((rdy_d & ((NUM_CH'(1) << sel_q) - NUM_CH'(1))) == '0)); // R4

endmodule

// File: rtl/rx_dma_sched.sv
// Module rx_dma_sched
// Top of the receive DMA request scheduler: one tracker per channel,
// an arbiter and the offer/burst controller.
// Assumes NUM_CH is a power of two and reads come only during a burst.
module rx_dma_sched #(
    parameter int NUM_CH = 8,
    parameter int OCC_W  = 6,
    parameter int EOF_W  = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] wr_en,
    input  logic [NUM_CH-1:0] wr_eof,
    input  logic [OCC_W-1:0]  cfg_high_wm,
    input  logic              cfg_rr_mode,
    output logic              dma_req,
    output logic [CH_W-1:0]   dma_ch,
    input  logic              dma_grant,
    output logic              burst_busy,
    input  logic              rd_en,
    input  logic              burst_done,
    output logic [OCC_W-1:0]  sel_occ,
    output logic [NUM_CH-1:0] chan_ready
);

    logic [NUM_CH-1:0][OCC_W-1:0] occ;
    logic [CH_W-1:0]              pick, last;
    logic                         pick_vld;

    // One tracker per channel; only the selected channel sees burst reads.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        rx_chan_tracker #(.OCC_W(OCC_W), .EOF_W(EOF_W)) u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (wr_en[c]),
            .eof_i   (wr_eof[c]),
            .rd_i    (burst_busy && rd_en && (dma_ch == CH_W'(c))),
            .hwm_i   (cfg_high_wm),
            .ready_o (chan_ready[c]),
            .occ_o   (occ[c])
        );
    end

    rx_sched_arbiter #(.NUM_CH(NUM_CH)) u_arb (
        .ready_i   (chan_ready),
        .rr_mode_i (cfg_rr_mode),
        .last_i    (last),
        .pick_o    (pick),
        .valid_o   (pick_vld)
    );

    rx_sched_fsm #(.NUM_CH(NUM_CH)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready_i    (chan_ready),
        .rr_mode_i  (cfg_rr_mode),
        .pick_i     (pick),
        .pick_vld_i (pick_vld),
        .grant_i    (dma_grant),
        .done_i     (burst_done),
        .sel_o      (dma_ch),
        .last_o     (last),
        .req_o      (dma_req),
        .busy_o     (burst_busy)
    );

    assign sel_occ = occ[dma_ch];

    AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        burst_busy |-> !dma_req); // R7

endmodule

// File: tb/tb_rx_dma_sched.sv
`timescale 1ns/1ps
module tb_rx_dma_sched;

    localparam int NCH = 8;
    localparam int OW  = 6;
    localparam int CW  = 3;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] wr_en, wr_eof;
    logic [OW-1:0]  cfg_high_wm;
    logic           cfg_rr_mode;
    logic           dma_req, dma_grant, burst_busy, rd_en, burst_done;
    logic [CW-1:0]  dma_ch;
    logic [OW-1:0]  sel_occ;
    logic [NCH-1:0] chan_ready;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    rx_dma_sched dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_eof(wr_eof),
        .cfg_high_wm(cfg_high_wm), .cfg_rr_mode(cfg_rr_mode),
        .dma_req(dma_req), .dma_ch(dma_ch), .dma_grant(dma_grant),
        .burst_busy(burst_busy), .rd_en(rd_en), .burst_done(burst_done),
        .sel_occ(sel_occ), .chan_ready(chan_ready)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <= 100000 cycles", cycles);
            summary();
            $finish;
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Write n dwords to every channel in mask; frame end on the last one.
    task automatic put(logic [NCH-1:0] mask, int n, bit eof_last);
        for (int i = 0; i < n; i++) begin
            wr_en  = mask;
            wr_eof = (eof_last && i == n - 1) ? mask : '0;
            step();
        end
        wr_en = '0; wr_eof = '0;
    endtask

    // Wait for an offer, check its channel, grant, read until empty.
    task automatic drain(int ch, int exp_n, string req);
        int n = 0;
        for (int w = 0; w < 20 && !dma_req; w++) step();
        chk({req, " offer"}, int'(dma_req), 1);
        chk({req, " channel"}, int'(dma_ch), ch);
        dma_grant = 1'b1; step(); dma_grant = 1'b0;
        chk({req, " busy"}, int'(burst_busy), 1);
        while (sel_occ != '0 && n < 64) begin
            rd_en = 1'b1; step(); n++;
        end
        rd_en = 1'b0;
        chk({req, " dwords read"}, n, exp_n);
        chk({req, " R9 ready clears"}, int'(chan_ready[ch]), 0);
        burst_done = 1'b1; step(); burst_done = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; step(3); rst_n = 1'b1; step();
        chk("R11 ready", int'(chan_ready), 0);
        chk("R11 req", int'(dma_req), 0);
        chk("R11 busy", int'(burst_busy), 0);
        chk("R11 sel_occ", int'(sel_occ), 0);
    endtask

    task automatic t_watermark();
        cfg_high_wm = 6'd4;
        put(8'h04, 4, 0);
        chk("R1 equal to watermark", int'(chan_ready[2]), 0);
        step(2);
        chk("R1 no req at watermark", int'(dma_req), 0);
        put(8'h04, 1, 0);
        chk("R1 above watermark", int'(chan_ready[2]), 1);
        chk("R7 req not yet", int'(dma_req), 0);
        step();
        chk("R7 req next edge", int'(dma_req), 1);
        drain(2, 5, "R1");
    endtask

    task automatic t_short_eof();
        cfg_high_wm = 6'd30;
        put(8'h20, 2, 1);
        chk("R2 short frame ready", int'(chan_ready[5]), 1);
        drain(5, 2, "R2");
    endtask

    task automatic t_empty_eof();
        cfg_high_wm = 6'd30;
        wr_eof = 8'h08; step(); wr_eof = '0;
        chk("R3 eof on empty", int'(chan_ready[3]), 0);
        step(2);
        chk("R3 no req", int'(dma_req), 0);
        put(8'h08, 1, 0);
        chk("R3 eof not kept", int'(chan_ready[3]), 0);
        wr_eof = 8'h08; step(); wr_eof = '0;
        chk("R2 eof marker with data", int'(chan_ready[3]), 1);
        drain(3, 1, "R3");
    endtask

    task automatic t_multi_packet();
        cfg_high_wm = 6'd30;
        put(8'h02, 2, 1);
        put(8'h02, 3, 1);
        drain(1, 5, "R8 across frames");
    endtask

    task automatic t_priority();
        cfg_high_wm = 6'd1; cfg_rr_mode = 1'b0;
        put(8'b0101_0010, 2, 0);
        drain(1, 2, "R4 first");
        drain(4, 2, "R4 second");
        drain(6, 2, "R4 third");
    endtask

    task automatic t_round_robin();
        cfg_high_wm = 6'd1; cfg_rr_mode = 1'b1;
        put(8'b1101_0010, 2, 0);
        drain(7, 2, "R5 after last 6");
        drain(1, 2, "R5 wrap");
        drain(4, 2, "R5 next");
        drain(6, 2, "R5 last");
    endtask

    task automatic t_mode_switch();
        cfg_high_wm = 6'd1; cfg_rr_mode = 1'b0;
        put(8'h08, 2, 0);
        drain(3, 2, "R6 setup");
        cfg_rr_mode = 1'b1;
        put(8'b0010_0010, 2, 0);
        step();
        chk("R6 rr picks after last", int'(dma_ch), 5);
        cfg_rr_mode = 1'b0;
        put(8'h10, 2, 0);
        drain(5, 2, "R6 offer kept");
        drain(1, 2, "R6 priority now");
        drain(4, 2, "R6 remaining");
    endtask

    task automatic t_hold();
        cfg_high_wm = 6'd1; cfg_rr_mode = 1'b0;
        put(8'h20, 2, 0);
        step();
        chk("R7 offered", int'(dma_ch), 5);
        put(8'h01, 2, 0);
        chk("R7 held on offer", int'(dma_ch), 5);
        drain(5, 2, "R7 held");
        drain(0, 2, "R7 next");
    endtask

    task automatic t_rw_same();
        cfg_high_wm = 6'd40;
        put(8'h04, 3, 1);
        step();
        chk("R10 offer", int'(dma_req), 1);
        dma_grant = 1'b1; step(); dma_grant = 1'b0;
        chk("R10 count", int'(sel_occ), 3);
        rd_en = 1'b1; wr_en = 8'h04; step(); wr_en = '0;
        chk("R10 write and read", int'(sel_occ), 3);
        step(3);
        chk("R10 drained", int'(sel_occ), 0);
        step();
        chk("R10 read when empty", int'(sel_occ), 0);
        rd_en = 1'b0;
        chk("R10 not ready", int'(chan_ready[2]), 0);
        burst_done = 1'b1; step(); burst_done = 1'b0;
        step(2);
        chk("R10 no new offer", int'(dma_req), 0);
    endtask

    initial begin
        rst_n = 1'b0; wr_en = '0; wr_eof = '0; cfg_high_wm = '0;
        cfg_rr_mode = 1'b0; dma_grant = 1'b0; rd_en = 1'b0; burst_done = 1'b0;
        #1;
        t_reset();
        t_watermark();
        t_short_eof();
        t_empty_eof();
        t_multi_packet();
        t_priority();
        t_round_robin();
        t_mode_switch();
        t_hold();
        t_rw_same();
        summary();
        $finish;
    end

endmodule